// File: doc/BRIEF.md
# Two-Stage Watchdog with Early Warning and Reset Request

This block is a watchdog timer on a small APB-style register bus. One up-counter is compared against two programmable limits. The lower limit raises a maskable early-warning interrupt. The upper limit raises a system reset request. Software keeps the system alive by writing a kick register, which returns the counter to zero. Counting and the warning interrupt are switched on by separate control bits.

A sticky cause flag sits in the power-on reset domain. The ordinary system reset does not touch it. After a reset, software can therefore tell whether the watchdog fired. The bus has zero wait states. A write takes effect on the clock edge of its access phase, and read data is valid during the access phase.

The register offsets are fixed by the `ALT_LAYOUT` parameter. The default layout is listed in R1. The alternate layout places kick, control, cause, warn threshold and fire threshold at 0x38, 0x40, 0x44, 0x4C and 0x5C.

Top module: `wdg_bark_bite`

## Requirements
- R1: In the default layout the registers sit at byte offsets 0x04 (kick), 0x08 (control), 0x0C (cause), 0x10 (warn threshold) and 0x14 (fire threshold). Control reads back its two bits in [1:0]. Both thresholds read back at the full counter width of 29 bits, so a value of 0x10000000 is held intact.
- R2: While control bit 0 is 1 and the count is below the fire threshold, the counter rises by exactly one per clock.
- R3: `bark_irq` is high exactly when control bits 0 and 1 are both 1 and count >= warn threshold. After a kick with warn = 20, it rises on the 20th following cycle. With bit 1 clear it stays low.
- R4: `bite_req` is high exactly when control bit 0 is 1 and count >= fire threshold. After a kick with fire = 40, it rises on the 40th following cycle.
- R5: A write with bit 0 = 1 to kick sets the count to zero on that edge. Control and both thresholds are unchanged. A write of 0 to kick has no effect.
- R6: While control bit 0 is 0, both outputs are low and the counter holds its value. Counting resumes from the held value when the bit is set again.
- R7: The counter stops at the fire threshold and does not wrap. `bite_req` therefore stays high until a kick, a disable or a system reset.
- R8: If warn and fire are equal and both control bits are 1, `bark_irq` and `bite_req` rise in the same cycle.
- R9: Cause bit 0 becomes 1 on any cycle in which `bite_req` is high. A system reset (`rst_n`) leaves it unchanged. Writing 1 to cause bit 0 clears it, writing 0 has no effect, and `por_n` clears it.
- R10: A system reset clears control, both thresholds and the counter. Reads of the kick register or of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| rst_n | input | 1 | System reset, active low, asynchronous; spares the cause flag |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read access |
| bark_irq | output | 1 | Early-warning interrupt, level |
| bite_req | output | 1 | System reset request, level |

## Verification
The counter is driven with four stimulus patterns.
- An uninterrupted run from a kick measures the exact rise cycles of both outputs.
- A run with the interrupt mask clear shows that the mask gates only the warning.
- A run paused mid-count and resumed separates a held counter from one that restarts or keeps counting.
- A run with equal limits confirms both events coincide.

A behavioural model predicts both outputs on every cycle. Register reads are checked across a system reset to show that the cause flag survives while the rest of the state clears.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_KICK  = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_CAUSE = 3'd3,
    SEL_WARN  = 3'd4,
    SEL_FIRE  = 3'd5
  } wdg_sel_e;

  localparam int unsigned NUM_SEL = 5;

  function automatic logic [7:0] offset_of(input wdg_sel_e s, input bit alt);
    logic [7:0] off;
    case (s)
      SEL_KICK:  off = alt ? 8'h38 : 8'h04;
      SEL_CTRL:  off = alt ? 8'h40 : 8'h08;
      SEL_CAUSE: off = alt ? 8'h44 : 8'h0C;
      SEL_WARN:  off = alt ? 8'h4C : 8'h10;
      SEL_FIRE:  off = alt ? 8'h5C : 8'h14;
      default:   off = 8'hFF;
    endcase
    return off;
  endfunction

endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W      = 29,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          ALT_LAYOUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic              cause_q,
  output logic [1:0]        ctrl_q,
  output logic [CNT_W-1:0]  warn_q,
  output logic [CNT_W-1:0]  fire_q,
  output logic              kick_o,
  output logic              cause_clr_o,
  output logic [31:0]       prdata
);
  wdg_sel_e sel;
  logic     wr_acc;
  logic     ctrl_we, warn_we, fire_we;
  logic [1:0]       ctrl_d;
  logic [CNT_W-1:0] warn_d, fire_d;
  logic unused_wdata;

  assign unused_wdata = ^pwdata[31:CNT_W];

  always_comb begin
    sel = SEL_NONE;
    for (int i = 1; i <= int'(NUM_SEL); i++) begin
      if (paddr == ADDR_W'(offset_of(wdg_sel_e'(3'(i)), ALT_LAYOUT)))
        sel = wdg_sel_e'(3'(i));
    end
  end

  assign wr_acc      = psel & penable & pwrite;
  assign ctrl_we     = wr_acc & (sel == SEL_CTRL);
  assign warn_we     = wr_acc & (sel == SEL_WARN);
  assign fire_we     = wr_acc & (sel == SEL_FIRE);
  assign kick_o      = wr_acc & (sel == SEL_KICK) & pwdata[0];
  assign cause_clr_o = wr_acc & (sel == SEL_CAUSE) & pwdata[0];

  always_comb begin
    ctrl_d = pwdata[1:0];
    warn_d = pwdata[CNT_W-1:0];
    fire_d = pwdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       warn_q <= '0;
    else if (warn_we) warn_q <= warn_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fire_q <= '0;
    else if (fire_we) fire_q <= fire_d;
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (sel)
        SEL_CTRL:  prdata[1:0]       = ctrl_q;
        SEL_CAUSE: prdata[0]         = cause_q;
        SEL_WARN:  prdata[CNT_W-1:0] = warn_q;
        SEL_FIRE:  prdata[CNT_W-1:0] = fire_q;
        default:   prdata            = '0;
      endcase
    end
  end

  // A kick must leave the programmed configuration alone.
  assert_kick_keeps_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |=> (ctrl_q == $past(ctrl_q)) && (fire_q == $past(fire_q)) && (warn_q == $past(warn_q)));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             kick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q
);
  logic             at_limit;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;

  assign at_limit = (cnt_q >= limit);
  assign cnt_en   = kick | (run & ~at_limit);

  always_comb begin
    if (kick) cnt_d = '0;
    else      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !kick && (cnt_q < limit)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_kick_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0));

  assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !kick) |=> $stable(cnt_q));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick && (cnt_q >= limit)) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/wdg_cause.sv
module wdg_cause (
  input  logic clk,
  input  logic por_n,
  input  logic set,
  input  logic clr,
  output logic cause_q
);
  logic cause_d;
  logic cause_en;

  assign cause_en = set | clr;
  assign cause_d  = set;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        cause_q <= 1'b0;
    else if (cause_en) cause_q <= cause_d;
  end

  assert_set_on_fire_R9: assert property (@(posedge clk) disable iff (!por_n)
    set |=> cause_q);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    (cause_q && !clr) |=> cause_q);
endmodule

// File: rtl/wdg_bark_bite.sv
module wdg_bark_bite #(
  parameter int unsigned CNT_W       = 29,
  parameter int unsigned ADDR_W      = 8,
  parameter bit          ALT_LAYOUT  = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              bark_irq,
  output logic              bite_req
);
  logic             sys_arst_n;
  logic             sys_rn;
  logic             por_rn;
  logic [1:0]       ctrl_q;
  logic [CNT_W-1:0] warn_q, fire_q, cnt_q;
  logic             kick, cause_clr, cause_q;

  assign sys_arst_n = rst_n & por_n;

  wdg_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk(clk), .arst_n(sys_arst_n), .srst_n(sys_rn));

  wdg_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_rn));

  wdg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .ALT_LAYOUT(ALT_LAYOUT)) u_regs (
    .clk(clk), .rst_n(sys_rn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .cause_q(cause_q), .ctrl_q(ctrl_q),
    .warn_q(warn_q), .fire_q(fire_q), .kick_o(kick), .cause_clr_o(cause_clr),
    .prdata(prdata));

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(sys_rn), .run(ctrl_q[0]), .kick(kick),
    .limit(fire_q), .cnt_q(cnt_q));

  wdg_cause u_cause (
    .clk(clk), .por_n(por_rn), .set(bite_req), .clr(cause_clr), .cause_q(cause_q));

  assign bark_irq = ctrl_q[0] & ctrl_q[1] & (cnt_q >= warn_q);
  assign bite_req = ctrl_q[0] & (cnt_q >= fire_q);

  assert_warn_before_fire_R3: assert property (@(posedge clk) disable iff (!sys_rn)
    ((ctrl_q == 2'b11) && (warn_q <= fire_q) && bite_req) |-> bark_irq);

  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!sys_rn)
    ((ctrl_q == 2'b11) && (warn_q == fire_q)) |-> (bark_irq == bite_req));

  assert_fire_persists_R7: assert property (@(posedge clk) disable iff (!sys_rn)
    (bite_req && !kick && !psel) |=> bite_req);
endmodule

// File: tb/wdg_bark_bite_bench.sv
module wdg_bark_bite_bench;
  localparam int CW = 29;
  localparam logic [7:0] A_KICK = 8'h04, A_CTRL = 8'h08, A_CAUSE = 8'h0C,
                         A_WARN = 8'h10, A_FIRE = 8'h14;

  logic clk = 1'b0;
  logic por_n, rst_n, psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic bark_irq, bite_req;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdg_bark_bite u_wdg_bark_bite (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .bark_irq(bark_irq), .bite_req(bite_req));

  // Behavioural reference model
  int unsigned m_cnt, m_warn, m_fire;
  int m_en, m_cause;
  int sys_age = 0, por_age = 0;

  always @(posedge clk) begin
    bit sys_act, por_act, wr, fire_now;
    int unsigned n_cnt;
    sys_act = (sys_age >= 2);
    por_act = (por_age >= 2);
    if (!(rst_n && por_n)) sys_age = 0; else if (sys_age < 10) sys_age++;
    if (!por_n) por_age = 0; else if (por_age < 10) por_age++;
    wr = psel && penable && pwrite;
    fire_now = sys_act && (m_en % 2 == 1) && (m_cnt >= m_fire);
    if (por_act) begin
      if (fire_now) m_cause = 1;
      else if (wr && paddr == A_CAUSE && pwdata[0]) m_cause = 0;
    end else m_cause = 0;
    if (!sys_act) begin
      m_en = 0; m_cnt = 0; m_warn = 0; m_fire = 0;
    end else begin
      n_cnt = m_cnt;
      if (wr && paddr == A_KICK && pwdata[0]) n_cnt = 0;
      else if ((m_en % 2 == 1) && m_cnt < m_fire) n_cnt = m_cnt + 1;
      if (wr && paddr == A_CTRL) m_en = int'(pwdata[1:0]);
      if (wr && paddr == A_WARN) m_warn = pwdata[CW-1:0];
      if (wr && paddr == A_FIRE) m_fire = pwdata[CW-1:0];
      m_cnt = n_cnt;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison of the outputs against the model (R3 R4 R6 R7 R8)
  always @(negedge clk) begin
    if (rst_n && por_n && sys_age >= 2) begin
      chk("R3 model bark_irq", {31'd0, bark_irq},
          {31'd0, (m_en == 3) && (m_cnt >= m_warn)});
      chk("R4 model bite_req", {31'd0, bite_req},
          {31'd0, (m_en % 2 == 1) && (m_cnt >= m_fire)});
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1;
    chk(tag, prdata, exp);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int n;
    por_n = 0; rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R10 reset bark_irq", {31'd0, bark_irq}, 0);
    chk("R10 reset bite_req", {31'd0, bite_req}, 0);
    bus_rd(A_CTRL, 0, "R10 reset control");
    bus_rd(A_CAUSE, 0, "R9 reset cause");
    bus_rd(A_WARN, 0, "R10 reset warn");

    // register map and 29-bit thresholds
    bus_wr(A_FIRE, 32'h1000_0000);
    bus_rd(A_FIRE, 32'h1000_0000, "R1 fire full width");
    bus_wr(A_WARN, 32'hFFFF_FFFF);
    bus_rd(A_WARN, 32'h1FFF_FFFF, "R1 warn width");
    bus_wr(A_WARN, 20);
    bus_wr(A_FIRE, 40);
    bus_rd(A_WARN, 20, "R1 warn readback");
    bus_rd(A_FIRE, 40, "R1 fire readback");

    // counting with warning masked
    bus_wr(A_CTRL, 1);
    repeat (30) @(negedge clk);
    chk("R3 masked bark_irq", {31'd0, bark_irq}, 0);
    chk("R4 below fire", {31'd0, bite_req}, 0);
    bus_rd(A_CTRL, 1, "R1 control readback");
    bus_wr(A_CTRL, 3);
    chk("R3 unmasked bark_irq", {31'd0, bark_irq}, 1);

    // timed run from a kick
    bus_wr(A_KICK, 1);
    chk("R5 kick clears bark", {31'd0, bark_irq}, 0);
    n = 0;
    while (!bark_irq && n < 200) begin @(negedge clk); n++; end
    chk("R3 bark rise cycle", n, 20);
    chk("R4 no bite at bark", {31'd0, bite_req}, 0);
    while (!bite_req && n < 200) begin @(negedge clk); n++; end
    chk("R4 bite rise cycle", n, 40);
    chk("R2 count reached fire", {31'd0, bite_req}, 1);

    // held at limit
    repeat (10) @(negedge clk);
    chk("R7 bite held", {31'd0, bite_req}, 1);
    bus_wr(A_KICK, 0);
    chk("R5 kick of zero ignored", {31'd0, bite_req}, 1);
    bus_wr(A_CTRL, 0);
    chk("R6 off bite", {31'd0, bite_req}, 0);
    chk("R6 off bark", {31'd0, bark_irq}, 0);
    bus_wr(A_CTRL, 3);
    chk("R7 no wrap, bite on resume", {31'd0, bite_req}, 1);

    // kick keeps configuration
    bus_wr(A_KICK, 1);
    chk("R5 kick clears bite", {31'd0, bite_req}, 0);
    bus_rd(A_CTRL, 3, "R5 control kept");
    bus_rd(A_WARN, 20, "R5 warn kept");
    bus_rd(A_FIRE, 40, "R5 fire kept");

    // pause mid-count: held value is 13
    bus_wr(A_KICK, 1);
    repeat (10) @(negedge clk);
    bus_wr(A_CTRL, 0);
    repeat (50) @(negedge clk);
    chk("R6 paused bark", {31'd0, bark_irq}, 0);
    bus_wr(A_CTRL, 3);
    n = 0;
    while (!bark_irq && n < 200) begin @(negedge clk); n++; end
    chk("R6 resume from held", n, 7);

    // equal limits
    bus_wr(A_CTRL, 0);
    bus_wr(A_WARN, 25);
    bus_wr(A_FIRE, 25);
    bus_wr(A_CTRL, 3);
    bus_wr(A_KICK, 1);
    n = 0;
    while (!bark_irq && !bite_req && n < 200) begin @(negedge clk); n++; end
    chk("R8 rise cycle", n, 25);
    chk("R8 bark with bite", {31'd0, bark_irq}, {31'd0, bite_req});

    // cause flag across system reset
    bus_rd(A_CAUSE, 1, "R9 cause set");
    bus_wr(A_CAUSE, 0);
    bus_rd(A_CAUSE, 1, "R9 write zero ignored");
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset drops bite", {31'd0, bite_req}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    bus_rd(A_CAUSE, 1, "R9 survives system reset");
    bus_rd(A_CTRL, 0, "R10 control cleared");
    bus_rd(A_FIRE, 0, "R10 fire cleared");
    bus_rd(A_KICK, 0, "R10 kick reads zero");
    bus_rd(8'h00, 0, "R10 unmapped reads zero");
    bus_wr(A_CAUSE, 1);
    bus_rd(A_CAUSE, 0, "R9 write one clears");

    done = 1'b1;
    finish_run();
  end
endmodule